// File: doc/BRIEF.md
# Legacy Shadow Window Attribute Router

This block sits on the memory request path and decides where each access to the legacy window between 0xC0000 and 0xEFFFF is sent. The window is cut into twelve 16 KB segments. Each segment carries a 2-bit attribute that chooses the destination for reads and the destination for writes on their own. A segment can send both kinds of access to the downstream I/O port or both to main memory. It can also serve reads from memory while writes go to the port, which write-protects a shadow copy. Or it can send writes to memory while reads still come from the port, which fills a shadow copy in line.

Software programs the attributes through a small register write port. Each 8-bit register covers two neighbouring segments, and a combinational read port returns the register at the selected index. A request is a valid strobe with an address, a write flag and a lock flag. One cycle later the block presents the destination and a hit flag. It also raises a split-lock flag when a locked access lands in a segment whose read and write destinations differ, because such an access completes without atomicity. Addresses outside the window report no hit and leave the destination at the I/O port.

Top module: `legacy_shadow_router`

## Requirements
- R1: After a synchronous reset every segment attribute is 00, cfg_rdata reads 0 at every index, and rsp_valid, rsp_hit, rsp_dest and rsp_split are all 0.
- R2: A request hits when its address lies in 0xC0000 to 0xEFFFF inclusive. The segment number is (address - 0xC0000) / 0x4000, giving segments 0 to 11. A request outside the window gives rsp_hit=0, rsp_dest=0 (I/O port) and rsp_split=0.
- R3: Register index k (0 to 5) holds segment 2k in bits [1:0] and segment 2k+1 in bits [5:4]. Bits [3:2] and [7:6] always read 0, whatever was written. Indexes 6 and 7 read 0, and writes to them change no segment.
- R4: rsp_dest encodes 0 as the I/O port and 1 as main memory. Attribute 00 sends both reads and writes to the I/O port.
- R5: Attribute 01 sends reads to main memory and writes to the I/O port.
- R6: Attribute 10 sends reads to the I/O port and writes to main memory.
- R7: Attribute 11 sends both reads and writes to main memory.
- R8: rsp_split is 1 exactly when the request hits, is locked, and its segment has attribute 01 or 10. The lock flag never changes rsp_dest.
- R9: The response registers hold the result of the request strobed at the previous clock edge. rsp_valid equals the previous req_valid. When no request was strobed, rsp_hit and rsp_split are 0.
- R10: A register write takes effect for requests presented in the following cycle. A request in the same cycle as the write is routed by the old attribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Attribute register write enable |
| cfg_idx | input | 3 | Attribute register index for write and read |
| cfg_wdata | input | 8 | Attribute register write data |
| cfg_rdata | output | 8 | Attribute register at cfg_idx (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W (32) | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_lock | input | 1 | Request belongs to a locked sequence |
| rsp_valid | output | 1 | Response registers carry a result |
| rsp_hit | output | 1 | Request fell inside the legacy window |
| rsp_dest | output | 1 | 0 = I/O port, 1 = main memory |
| rsp_split | output | 1 | Locked access to a segment with differing read and write destinations |

## Verification
The hardest case to reach is a register write and a request to the same segment in the same cycle. Here the old attribute must route the request, and the new attribute must route a request one cycle later. The stimulus sets up this case on purpose, with back-to-back requests around a write that flips a segment from write-protect to shadow. Further stimulus programs the four attribute values in a rotating pattern across all twelve segments. It then probes the first and last byte of each segment with every combination of read, write and lock. Random traffic follows, mixing writes that carry junk bits and addresses just outside both ends of the window.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int SEG_SHIFT  = 14;
    localparam int FIRST_BLK  = 48;
    localparam int NUM_SEGS   = 12;
    localparam int NUM_REGS   = NUM_SEGS / 2;
    localparam int SEG_W      = $clog2(NUM_SEGS);
    localparam int CFG_IDX_W  = 3;
    localparam int CFG_DATA_W = 8;

    typedef logic [1:0] attr_t;

    typedef enum logic {
        DEST_IO  = 1'b0,
        DEST_MEM = 1'b1
    } dest_e;

    typedef struct packed {
        logic  hit;
        dest_e dest;
        logic  split;
    } route_t;

    function automatic dest_e read_dest(attr_t a);
        return a[0] ? DEST_MEM : DEST_IO;
    endfunction

    function automatic dest_e write_dest(attr_t a);
        return a[1] ? DEST_MEM : DEST_IO;
    endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int IDX_W  = CFG_IDX_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic [CFG_DATA_W-1:0]       wdata,
    output logic [CFG_DATA_W-1:0]       rdata,
    output attr_t [2*N_REGS-1:0]        seg_attr
);

    attr_t lo_q [N_REGS];
    attr_t hi_q [N_REGS];

    for (genvar k = 0; k < N_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[k] <= '0;
                hi_q[k] <= '0;
            end else if (we && idx == IDX_W'(k)) begin
                lo_q[k] <= wdata[1:0];
                hi_q[k] <= wdata[5:4];
            end
        end
        assign seg_attr[2*k]   = lo_q[k];
        assign seg_attr[2*k+1] = hi_q[k];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_REGS; k++) begin
            if (idx == IDX_W'(k)) begin
                rdata = {2'b00, hi_q[k], 2'b00, lo_q[k]};
            end
        end
    end

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEG_W-1:0]  seg
);

    localparam int BLK_W = ADDR_W - SEG_SHIFT;

    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] off;

    assign blk = addr[ADDR_W-1:SEG_SHIFT];
    assign off = blk - BLK_W'(FIRST_BLK);
    assign hit = (blk >= BLK_W'(FIRST_BLK)) && (off < BLK_W'(NUM_SEGS));
    assign seg = hit ? off[SEG_W-1:0] : '0;

endmodule

// File: rtl/shadow_route_pick.sv
module shadow_route_pick
    import shadow_pkg::*;
(
    input  logic   hit,
    input  attr_t  attr,
    input  logic   is_write,
    input  logic   lock,
    output route_t route
);

    dest_e rd_d;
    dest_e wr_d;

    always_comb begin
        rd_d        = read_dest(attr);
        wr_d        = write_dest(attr);
        route.hit   = hit;
        route.dest  = !hit ? DEST_IO : (is_write ? wr_d : rd_d);
        route.split = hit && lock && (rd_d != wr_d);
    end

endmodule

// File: rtl/legacy_shadow_router.sv
module legacy_shadow_router
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_IDX_W-1:0]  cfg_idx,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic                  req_lock,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_dest,
    output logic                  rsp_split
);

    attr_t [NUM_SEGS-1:0] seg_attr;
    logic                 dec_hit;
    logic [SEG_W-1:0]     dec_seg;
    attr_t                cur_attr;
    route_t               route_d;
    route_t               route_q;
    logic                 valid_q;

    shadow_attr_regs #(
        .N_REGS (NUM_REGS),
        .IDX_W  (CFG_IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .seg_attr (seg_attr)
    );

    shadow_seg_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (req_addr),
        .hit  (dec_hit),
        .seg  (dec_seg)
    );

    always_comb begin
        cur_attr = '0;
        for (int s = 0; s < NUM_SEGS; s++) begin
            if (dec_seg == SEG_W'(s)) begin
                cur_attr = seg_attr[s];
            end
        end
    end

    shadow_route_pick u_pick (
        .hit      (dec_hit),
        .attr     (cur_attr),
        .is_write (req_write),
        .lock     (req_lock),
        .route    (route_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            route_q <= '{hit: 1'b0, dest: DEST_IO, split: 1'b0};
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                route_q <= route_d;
            end else begin
                route_q <= '{hit: 1'b0, dest: DEST_IO, split: 1'b0};
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_hit   = route_q.hit;
    assign rsp_dest  = route_q.dest;
    assign rsp_split = route_q.split;

endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CFG_IDX_W-1:0]  cfg_idx,
    input logic [CFG_DATA_W-1:0] cfg_rdata,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  req_lock,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic                  rsp_dest,
    input logic                  rsp_split
);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_split));

    a_r2_below_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr < ADDR_W'(32'hC0000)) |=> (!rsp_hit && rsp_dest == 1'b0));

    a_r2_above_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr > ADDR_W'(32'hEFFFF)) |=> (!rsp_hit && !rsp_split));

    a_r8_split_needs_lock: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_lock) |=> !rsp_split);

    a_r8_split_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_split |-> rsp_hit);

    a_r3_pad_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[3:2] == 2'b00) && (cfg_rdata[7:6] == 2'b00));

    a_r3_spare_idx_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx >= CFG_IDX_W'(NUM_REGS)) |-> (cfg_rdata == '0));

endmodule

bind legacy_shadow_router shadow_router_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_legacy_shadow_router.sv
module tb_legacy_shadow_router;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_idx = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_lock = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_dest, rsp_split;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int    m_attr [12];
    logic  e_valid = 0, e_hit = 0, e_dest = 0, e_split = 0;
    string e_tag = "R1";
    logic  model_on = 0;

    always #4 clk = ~clk;

    legacy_shadow_router #(.ADDR_W(ADDR_W)) dut (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural model: update at each rising edge from sampled inputs
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 12; s++) m_attr[s] = 0;
            e_valid = 0; e_hit = 0; e_dest = 0; e_split = 0; e_tag = "R1";
        end else begin
            longint a;
            a = longint'(req_addr);
            e_valid = req_valid;
            e_hit = 0; e_dest = 0; e_split = 0; e_tag = "R9";
            if (req_valid) begin
                if (a >= 64'hC0000 && a <= 64'hEFFFF) begin
                    int sg, at;
                    bit rd_mem, wr_mem;
                    sg = int'((a - 64'hC0000) / 64'h4000);
                    at = m_attr[sg];
                    rd_mem = (at == 1) || (at == 3);
                    wr_mem = (at == 2) || (at == 3);
                    e_hit = 1;
                    e_dest = req_write ? wr_mem : rd_mem;
                    e_split = req_lock && (rd_mem != wr_mem);
                    case (at)
                        0: e_tag = "R4";
                        1: e_tag = "R5";
                        2: e_tag = "R6";
                        default: e_tag = "R7";
                    endcase
                end else begin
                    e_tag = "R2";
                end
            end
            if (cfg_we && cfg_idx < 6) begin
                m_attr[2*cfg_idx]   = int'(cfg_wdata[1:0]);
                m_attr[2*cfg_idx+1] = int'(cfg_wdata[5:4]);
            end
        end
    end

    function automatic int model_rdata(input int idx);
        if (idx >= 6) return 0;
        return (m_attr[2*idx+1] << 4) | m_attr[2*idx];
    endfunction

    // compare away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (model_on && !rst) begin
            chk("R9", "rsp_valid", rsp_valid, e_valid);
            chk(e_tag, "rsp_hit", rsp_hit, e_hit);
            chk(e_tag, "rsp_dest", rsp_dest, e_dest);
            chk("R8", "rsp_split", rsp_split, e_split);
            chk("R3", "cfg_rdata", cfg_rdata, model_rdata(int'(cfg_idx)));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg_write(input int idx, input int data);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = 8'(data);
        tick();
        cfg_we = 0;
    endtask

    task automatic request(input longint addr, input bit wr, input bit lk);
        req_valid = 1; req_addr = ADDR_W'(addr); req_write = wr; req_lock = lk;
        tick();
        req_valid = 0;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state at the ports
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "rsp_hit", rsp_hit, 0);
        chk("R1", "rsp_dest", rsp_dest, 0);
        chk("R1", "rsp_split", rsp_split, 0);
        for (int i = 0; i < 8; i++) begin
            cfg_idx = 3'(i);
            #1;
            chk("R1", "cfg_rdata after reset", cfg_rdata, 0);
        end
        model_on = 1;

        // R4: default routing, all segments to I/O port
        request(64'hC0000, 0, 1);
        request(64'hEFFFF, 1, 1);

        // R3: junk bits dropped, spare indexes ignored
        cfg_write(0, 8'hFF);
        cfg_idx = 0; tick();
        chk("R3", "pad bits read zero", cfg_rdata, 8'h33);
        cfg_write(6, 8'hFF);
        cfg_write(7, 8'h33);
        for (int i = 0; i < 8; i++) begin
            cfg_idx = 3'(i); tick();
        end
        cfg_write(0, 0);

        // R4..R8: rotating attributes across all segments
        for (int rot = 0; rot < 4; rot++) begin
            for (int r = 0; r < 6; r++) begin
                int lo, hi;
                lo = (2*r + rot) % 4;
                hi = (2*r + 1 + rot) % 4;
                cfg_write(r, (hi << 4) | lo | 8'hCC);
            end
            for (int s = 0; s < 12; s++) begin
                for (int m = 0; m < 4; m++) begin
                    request(64'hC0000 + s*64'h4000, m[0], m[1]);
                    request(64'hC0000 + s*64'h4000 + 64'h3FFF, m[0], m[1]);
                end
            end
        end

        // R2: just outside both ends and aliases above 1 MB
        request(64'hBFFFF, 0, 1);
        request(64'hF0000, 1, 1);
        request(64'h100C0000, 0, 1);
        request(64'h0, 1, 0);

        // R10: write and request to the same segment in one cycle
        cfg_write(1, 8'h01);
        req_valid = 1; req_addr = ADDR_W'(32'hC8000); req_write = 0; req_lock = 1;
        cfg_we = 1; cfg_idx = 1; cfg_wdata = 8'h02;
        tick();
        cfg_we = 0;
        tick();
        req_valid = 0;
        tick();

        // R9: idle gaps and random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 5) == 0)
                cfg_write($urandom_range(0, 7), $urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) begin
                tick();
            end else begin
                request(64'hBC000 + longint'($urandom_range(0, 32'h3BFFF)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
        end
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule